// File: doc/BRIEF.md
# Multi-Pair Audio Transmit Serializer

This block is the transmit side of an I2S master that drives up to four stereo pairs. Each pair has its own serial data line. Software writes samples through a small memory-mapped register port. A write to a pair's left holding register latches the left sample. A write to its right holding register pushes the stereo frame into that pair's FIFO. Bit clock (SCLK) and word select (WS) come from a shared clock generator. Both are synchronous to the system clock. The block watches them for SCLK falling edges and WS transitions. It pops one frame per WS period and shifts each sample out MSB first. The sample is left-aligned in its slot, and zeros fill the unused low bits.

Serial output on a pair needs three enables to be set together: the global enable, the transmit-block enable and that pair's own enable. Each pair reports two status conditions:
- A FIFO-level trigger, set while the fill count is at or below a programmed threshold.
- A sticky overrun flag, set when a frame is written while the FIFO is full.

A per-pair mask decides which status conditions reach the single interrupt output. A single command empties all FIFOs at once.

Top module: `i2s_tx_multi`

## Requirements
- R1: After reset:
  - the per-pair mask register reads 0x30;
  - the resolution register reads 2;
  - the trigger register reads 0;
  - the global enable reads 0;
  - every data line is 0;
  - the interrupt is 0.
- R2: Register map:
  - Global registers: enable at 0x000 (bit 0), transmit-block enable at 0x004 (bit 0), flush at 0x008 (bit 0).
  - Pair p has a window at base 0x40*p, with these offsets: left hold +0x20, right hold +0x24, pair enable +0x28 (bit 0), resolution +0x2C (bits 2:0), status +0x30 (read only), mask +0x34 (bits 5:4), overrun clear +0x38, trigger +0x3C.
  - Writing the right hold register pushes the frame {latest left, right} into the pair's FIFO.
- R3: Resolution codes select the sample width: 2 means 16 bits, 4 means 24 bits, and 5 or any other code means 32 bits. The low N bits of each written sample go out MSB first. Zeros fill the rest of the 32-bit slot.
- R4: Slot timing and bit order:
  - WS=0 carries the left sample and WS=1 carries the right sample.
  - A sample's MSB is driven at the SCLK falling edge after the edge where WS changed.
  - A data line changes only in the clock cycle after a detected SCLK fall.
  - A slot lasts one WS half-period, which must be 32 SCLK periods.
- R5: A pair pops its FIFO and drives data only while the global, transmit-block and pair enables are all 1. Otherwise its line is held at 0 and its FIFO is left untouched.
- R6: If a pair is running and its FIFO is empty at the start of a left slot, both slots of that frame carry zeros.
- R7: Status bit 4 is 1 exactly while the pair's FIFO fill count is at or below its trigger value.
- R8: Writing the right hold register while the FIFO is full sets status bit 5 and drops that frame. The frames already queued are sent unchanged.
- R9: Any read or write access to a pair's overrun-clear register clears its status bit 5. A new overrun in the same cycle takes priority and keeps the flag set.
- R10: Writing 1 to bit 0 of the flush register empties every pair's FIFO. Writing 0 there has no effect.
- R11: The interrupt output is 1 when, for any pair, (status bit 4 AND NOT mask bit 4) OR (status bit 5 AND NOT mask bit 5) holds.
- R12: Each FIFO holds FIFO_DEPTH frames. Its fill count never exceeds that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (used for the read side effect of the overrun-clear register) |
| busAddr | input | ADDR_W | Register byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from the address |
| sclk | input | 1 | Bit clock from the shared generator, synchronous to clk |
| ws | input | 1 | Word select from the shared generator, changes together with an SCLK fall |
| sdOut | output | NUM_PAIRS | Serial data, one line per stereo pair |
| irq | output | 1 | Combined unmasked status interrupt |

## Verification
The assertions assume the following about the inputs:
- WS changes only in a cycle where SCLK falls.
- SCLK stays high and low for at least one system clock each.
- The bus issues at most one access per cycle.

The stimulus meets these assumptions by construction. A single bench process divides the clock by four for SCLK and toggles WS every 32 SCLK falls. Bus accesses are serialised through one write task and one read task. Samples are random, with bit 0 forced to 1, so that every transmitted frame is nonzero. The bench receiver can then skip the all-zero frames sent during idle and underrun periods and still match the queued sequence exactly.

// File: rtl/i2stx_pkg.sv
package i2stx_pkg;
  localparam int SLOT_W  = 32;
  localparam int FRAME_W = 2 * SLOT_W;

  localparam int PAIR_STRIDE = 64;
  localparam int ADR_GLB   = 0;
  localparam int ADR_TXB   = 4;
  localparam int ADR_FLUSH = 8;
  localparam int OFF_LEFT  = 32;
  localparam int OFF_RIGHT = 36;
  localparam int OFF_PEN   = 40;
  localparam int OFF_RES   = 44;
  localparam int OFF_STAT  = 48;
  localparam int OFF_MASK  = 52;
  localparam int OFF_OVCLR = 56;
  localparam int OFF_TRIG  = 60;

  localparam logic [2:0] RES_16 = 3'd2;
  localparam logic [2:0] RES_24 = 3'd4;

  typedef struct packed {
    logic wrLeft;
    logic wrRight;
  } pairStb_t;

  typedef struct packed {
    logic       run;
    logic [2:0] res;
  } pairCfg_t;

  // place the active sample bits at the top of the slot, zero below
  function automatic logic [SLOT_W-1:0] alignSample(input logic [SLOT_W-1:0] s,
                                                    input logic [2:0] code);
    case (code)
      RES_16:  return {s[15:0], 16'h0000};
      RES_24:  return {s[23:0], 8'h00};
      default: return s;
    endcase
  endfunction
endpackage

// File: rtl/i2stx_fifo.sv
module i2stx_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] cntQ;
  logic doPush, doPop;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (cntQ == CNT_W'(DEPTH));
  assign empty  = (cntQ == '0);
  assign doPush = push & ~full & ~flush;
  assign doPop  = pop & ~empty & ~flush;
  assign dout   = mem[rdPtr];
  assign count  = cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cntQ  <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cntQ  <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      cntQ <= cntQ + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end
endmodule

// File: rtl/i2stx_serial.sv
module i2stx_serial
  import i2stx_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               fallTick,
  input  logic               wsNow,
  input  pairCfg_t           cfg,
  input  logic               fifoEmpty,
  input  logic [FRAME_W-1:0] head,
  output logic               pop,
  output logic               sd
);
  logic              wsQ;
  logic [SLOT_W-1:0] shiftQ, rightQ;
  logic              wsEdge, leftStart;

  assign wsEdge    = fallTick & (wsNow != wsQ);
  assign leftStart = wsEdge & ~wsNow;
  assign pop       = leftStart & cfg.run & ~fifoEmpty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wsQ    <= 1'b0;
      shiftQ <= '0;
      rightQ <= '0;
      sd     <= 1'b0;
    end else if (fallTick) begin
      wsQ <= wsNow;
      if (!cfg.run) begin
        sd     <= 1'b0;
        shiftQ <= '0;
        rightQ <= '0;
      end else begin
        sd <= shiftQ[SLOT_W-1];
        if (leftStart) begin
          shiftQ <= fifoEmpty ? '0 : alignSample(head[FRAME_W-1:SLOT_W], cfg.res);
          rightQ <= fifoEmpty ? '0 : alignSample(head[SLOT_W-1:0], cfg.res);
        end else if (wsEdge) begin
          shiftQ <= rightQ;
        end else begin
          shiftQ <= {shiftQ[SLOT_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/i2stx_ctrl.sv
module i2stx_ctrl
  import i2stx_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  parameter int ADDR_W    = 9,
  parameter int CNT_W     = 3
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              busWr,
  input  logic                              busRd,
  input  logic [ADDR_W-1:0]                 busAddr,
  input  logic [31:0]                       busWdata,
  output logic [31:0]                       busRdata,
  input  logic [NUM_PAIRS-1:0]              ovrSet,
  input  logic [NUM_PAIRS-1:0][CNT_W-1:0]   fifoCnt,
  output pairStb_t [NUM_PAIRS-1:0]          stb,
  output pairCfg_t [NUM_PAIRS-1:0]          cfg,
  output logic                              flush,
  output logic                              irq
);
  logic glbEnQ, txEnQ;
  logic [NUM_PAIRS-1:0]             pairEnQ, ovrQ, lvlHit;
  logic [NUM_PAIRS-1:0][2:0]        resQ;
  logic [NUM_PAIRS-1:0][1:0]        maskQ;
  logic [NUM_PAIRS-1:0][CNT_W-1:0]  trigQ;

  function automatic logic hitG(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  function automatic logic hitP(input logic [ADDR_W-1:0] a, input int p, input int off);
    return a == ADDR_W'(p * PAIR_STRIDE + off);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      glbEnQ  <= 1'b0;
      txEnQ   <= 1'b0;
      pairEnQ <= '0;
      ovrQ    <= '0;
      resQ    <= {NUM_PAIRS{3'd2}};
      maskQ   <= '1;
      trigQ   <= '0;
    end else begin
      if (busWr && hitG(busAddr, ADR_GLB)) glbEnQ <= busWdata[0];
      if (busWr && hitG(busAddr, ADR_TXB)) txEnQ  <= busWdata[0];
      for (int p = 0; p < NUM_PAIRS; p++) begin
        if (busWr && hitP(busAddr, p, OFF_PEN))  pairEnQ[p] <= busWdata[0];
        if (busWr && hitP(busAddr, p, OFF_RES))  resQ[p]    <= busWdata[2:0];
        if (busWr && hitP(busAddr, p, OFF_MASK)) maskQ[p]   <= busWdata[5:4];
        if (busWr && hitP(busAddr, p, OFF_TRIG)) trigQ[p]   <= busWdata[CNT_W-1:0];
        if (ovrSet[p])
          ovrQ[p] <= 1'b1;
        else if ((busWr || busRd) && hitP(busAddr, p, OFF_OVCLR))
          ovrQ[p] <= 1'b0;
      end
    end
  end

  always_comb begin
    flush    = busWr && hitG(busAddr, ADR_FLUSH) && busWdata[0];
    irq      = 1'b0;
    busRdata = '0;
    lvlHit   = '0;
    if (hitG(busAddr, ADR_GLB)) busRdata = {31'b0, glbEnQ};
    if (hitG(busAddr, ADR_TXB)) busRdata = {31'b0, txEnQ};
    for (int p = 0; p < NUM_PAIRS; p++) begin
      stb[p].wrLeft  = busWr && hitP(busAddr, p, OFF_LEFT);
      stb[p].wrRight = busWr && hitP(busAddr, p, OFF_RIGHT);
      cfg[p].run     = glbEnQ & txEnQ & pairEnQ[p];
      cfg[p].res     = resQ[p];
      lvlHit[p]      = fifoCnt[p] <= trigQ[p];
      irq = irq | (lvlHit[p] & ~maskQ[p][0]) | (ovrQ[p] & ~maskQ[p][1]);
      if (hitP(busAddr, p, OFF_PEN))  busRdata = {31'b0, pairEnQ[p]};
      if (hitP(busAddr, p, OFF_RES))  busRdata = {29'b0, resQ[p]};
      if (hitP(busAddr, p, OFF_STAT)) busRdata = {26'b0, ovrQ[p], lvlHit[p], 4'b0};
      if (hitP(busAddr, p, OFF_MASK)) busRdata = {26'b0, maskQ[p], 4'b0};
      if (hitP(busAddr, p, OFF_TRIG)) busRdata = 32'(trigQ[p]);
    end
  end
endmodule

// File: rtl/i2stx_datapath.sv
module i2stx_datapath
  import i2stx_pkg::*;
#(
  parameter int NUM_PAIRS  = 4,
  parameter int FIFO_DEPTH = 4,
  parameter int CNT_W      = 3
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            sclk,
  input  logic                            ws,
  input  pairStb_t [NUM_PAIRS-1:0]        stb,
  input  pairCfg_t [NUM_PAIRS-1:0]        cfg,
  input  logic                            flush,
  input  logic [31:0]                     wdata,
  output logic [NUM_PAIRS-1:0]            ovrSet,
  output logic [NUM_PAIRS-1:0][CNT_W-1:0] fifoCnt,
  output logic [NUM_PAIRS-1:0]            sdOut,
  output logic                            sclkFall
);
  logic sclkQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkQ <= 1'b0;
    else       sclkQ <= sclk;
  end

  assign sclkFall = sclkQ & ~sclk;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : gPair
    logic [SLOT_W-1:0]  leftHoldQ;
    logic [FRAME_W-1:0] head;
    logic full, empty, pop;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              leftHoldQ <= '0;
      else if (stb[p].wrLeft) leftHoldQ <= wdata;
    end

    assign ovrSet[p] = stb[p].wrRight & full;

    i2stx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(FRAME_W), .CNT_W(CNT_W)) uFifo (
      .clk(clk), .rstN(rstN), .flush(flush),
      .push(stb[p].wrRight), .din({leftHoldQ, wdata}),
      .pop(pop), .dout(head), .count(fifoCnt[p]),
      .full(full), .empty(empty)
    );

    i2stx_serial uSer (
      .clk(clk), .rstN(rstN), .fallTick(sclkFall), .wsNow(ws),
      .cfg(cfg[p]), .fifoEmpty(empty), .head(head),
      .pop(pop), .sd(sdOut[p])
    );
  end
endmodule

// File: rtl/i2s_tx_multi.sv
module i2s_tx_multi
  import i2stx_pkg::*;
#(
  parameter int NUM_PAIRS  = 4,
  parameter int FIFO_DEPTH = 4,
  parameter int ADDR_W     = 9
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWr,
  input  logic                 busRd,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic                 sclk,
  input  logic                 ws,
  output logic [NUM_PAIRS-1:0] sdOut,
  output logic                 irq
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  pairStb_t [NUM_PAIRS-1:0]        stb;
  pairCfg_t [NUM_PAIRS-1:0]        cfg;
  logic [NUM_PAIRS-1:0]            ovrSet;
  logic [NUM_PAIRS-1:0][CNT_W-1:0] fifoCnt;
  logic [NUM_PAIRS-1:0]            runVec;
  logic                            flush, sclkFall;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : gRun
    assign runVec[p] = cfg[p].run;
  end

  i2stx_ctrl #(.NUM_PAIRS(NUM_PAIRS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .ovrSet(ovrSet), .fifoCnt(fifoCnt),
    .stb(stb), .cfg(cfg), .flush(flush), .irq(irq)
  );

  i2stx_datapath #(.NUM_PAIRS(NUM_PAIRS), .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .sclk(sclk), .ws(ws), .stb(stb), .cfg(cfg),
    .flush(flush), .wdata(busWdata), .ovrSet(ovrSet), .fifoCnt(fifoCnt),
    .sdOut(sdOut), .sclkFall(sclkFall)
  );
endmodule

// File: rtl/i2s_tx_multi_chk.sv
module i2s_tx_multi_chk #(
  parameter int NUM_PAIRS  = 4,
  parameter int FIFO_DEPTH = 4,
  parameter int ADDR_W     = 9,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            busWr,
  input logic [ADDR_W-1:0]               busAddr,
  input logic [31:0]                     busWdata,
  input logic [NUM_PAIRS-1:0]            sdOut,
  input logic                            sclkFall,
  input logic [NUM_PAIRS-1:0]            runVec,
  input logic [NUM_PAIRS-1:0]            ovrSet,
  input logic [NUM_PAIRS-1:0][CNT_W-1:0] fifoCnt
);
  // R4
  sd_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sclkFall |=> $stable(sdOut));

  // R10
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_W'(8) && busWdata[0]) |=> (fifoCnt == '0));

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : gChk
    // R12
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
      fifoCnt[p] <= CNT_W'(FIFO_DEPTH));

    // R5
    idle_line_low_chk: assert property (@(posedge clk) disable iff (!rstN)
      (sclkFall && !runVec[p]) |=> !sdOut[p]);

    // R8
    overrun_only_full_chk: assert property (@(posedge clk) disable iff (!rstN)
      ovrSet[p] |-> (fifoCnt[p] == CNT_W'(FIFO_DEPTH)));
  end
endmodule

bind i2s_tx_multi i2s_tx_multi_chk #(
  .NUM_PAIRS(NUM_PAIRS), .FIFO_DEPTH(FIFO_DEPTH), .ADDR_W(ADDR_W)
) uChk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
  .sdOut(sdOut), .sclkFall(sclkFall), .runVec(runVec), .ovrSet(ovrSet),
  .fifoCnt(fifoCnt)
);

// File: tb/tb_i2s_tx_multi.sv
module tb_i2s_tx_multi;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NP = 4, DEPTH = 4, AW = 9, SLOT = 32;
  localparam int FRAME_CLKS = 2 * SLOT * 4;

  logic clk = 1'b0, rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic busWr = 1'b0, busRd = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic sclk = 1'b0, ws = 1'b0;
  logic [NP-1:0] sdOut;
  logic irq;

  i2s_tx_multi #(.NUM_PAIRS(NP), .FIFO_DEPTH(DEPTH), .ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .sclk(sclk), .ws(ws),
    .sdOut(sdOut), .irq(irq)
  );

  int nChecks = 0, nFails = 0;
  logic [63:0] expQ [NP][$];
  logic [63:0] rxQ  [NP][$];
  logic [31:0] acc [NP];
  logic [31:0] leftTmp [NP];
  logic [2:0]  resSel [NP];
  int          cntModel [NP];
  logic        wsSeen = 1'b0;
  int          phase = 0, fallCnt = 0;
  logic        doneFlag = 1'b0;

  function automatic logic [31:0] benchAlign(input logic [31:0] s, input logic [2:0] code);
    int n;
    n = (code == 3'd2) ? 16 : (code == 3'd4) ? 24 : 32;
    return s << (32 - n);
  endfunction

  function automatic int pa(input int p, input int off);
    return p * 64 + off;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sampleRise();
    for (int p = 0; p < NP; p++) begin
      acc[p] = {acc[p][30:0], sdOut[p]};
      if (ws != wsSeen) begin
        if (!wsSeen) leftTmp[p] = acc[p];
        else if ({leftTmp[p], acc[p]} != 64'd0) rxQ[p].push_back({leftTmp[p], acc[p]});
      end
    end
    wsSeen = ws;
  endtask

  // shared SCLK / WS source: SCLK = clk/4, WS toggles every SLOT falls
  initial begin
    for (int p = 0; p < NP; p++) begin acc[p] = '0; leftTmp[p] = '0; end
    forever begin
      @(negedge clk);
      if (phase == 0) begin
        sclk = 1'b0;
        fallCnt++;
        if (fallCnt == SLOT) begin fallCnt = 0; ws = ~ws; end
      end else if (phase == 2) begin
        sclk = 1'b1;
        sampleRise();
      end
      phase = (phase + 1) % 4;
    end
  end

  task automatic busWrite(input int a, input logic [31:0] d);
    @(negedge clk); busWr = 1'b1; busAddr = AW'(a); busWdata = d;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic busRead(input int a, output logic [31:0] d);
    @(negedge clk); busRd = 1'b1; busAddr = AW'(a);
    #1 d = busRdata;
    @(negedge clk); busRd = 1'b0;
  endtask

  task automatic pushFrame(input int p);
    logic [31:0] l, r;
    l = $urandom | 32'h1;
    r = $urandom | 32'h1;
    busWrite(pa(p, 32), l);
    busWrite(pa(p, 36), r);
    if (cntModel[p] < DEPTH) begin
      cntModel[p]++;
      expQ[p].push_back({benchAlign(l, resSel[p]), benchAlign(r, resSel[p])});
    end
  endtask

  task automatic setRes(input int p, input logic [2:0] code);
    resSel[p] = code;
    busWrite(pa(p, 44), {29'b0, code});
  endtask

  task automatic waitFrames(input int n);
    repeat (n * FRAME_CLKS) @(negedge clk);
  endtask

  task automatic compareRx(input int p, input string tag);
    check({tag, " frame count"}, 64'(rxQ[p].size()), 64'(expQ[p].size()));
    while (rxQ[p].size() > 0 && expQ[p].size() > 0)
      check({tag, " frame data"}, rxQ[p].pop_front(), expQ[p].pop_front());
    rxQ[p].delete();
    expQ[p].delete();
    cntModel[p] = 0;
  endtask

  task automatic runPairs(input logic [NP-1:0] sel, input int frames);
    for (int p = 0; p < NP; p++) if (sel[p]) busWrite(pa(p, 40), 1);
    waitFrames(frames);
    for (int p = 0; p < NP; p++) if (sel[p]) busWrite(pa(p, 40), 0);
    waitFrames(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!doneFlag) begin
      nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int seed;
    seed = $urandom(32'd20240611);
    for (int p = 0; p < NP; p++) begin resSel[p] = 3'd2; cntModel[p] = 0; end
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    check("R1 sdOut", 64'(sdOut), 64'd0);
    check("R1 irq", 64'(irq), 64'd0);
    busRead(pa(0, 52), rd); check("R1 mask", 64'(rd), 64'h30);
    busRead(pa(3, 44), rd); check("R1 resolution", 64'(rd), 64'd2);
    busRead(pa(1, 60), rd); check("R1 trigger", 64'(rd), 64'd0);
    busRead(0, rd);         check("R1 global enable", 64'(rd), 64'd0);
    busRead(pa(0, 48), rd); check("R7 status empty at trig 0", 64'(rd), 64'h10);

    // R2 R3 R4 main transfer, one resolution per pair
    busWrite(0, 1);
    busWrite(4, 1);
    setRes(0, 3'd2); setRes(1, 3'd4); setRes(2, 3'd5); setRes(3, 3'd4);
    for (int p = 0; p < NP; p++) begin
      busWrite(pa(p, 60), 2);
      for (int k = 0; k < DEPTH; k++) pushFrame(p);
      busRead(pa(p, 48), rd); check("R7 status above trigger", 64'(rd), 64'h0);
    end
    check("R11 irq masked", 64'(irq), 64'd0);
    runPairs(4'b1111, 7);
    for (int p = 0; p < NP; p++) compareRx(p, "R3 R4 R2 serial");
    busRead(pa(2, 48), rd); check("R7 status after drain", 64'(rd), 64'h10);
    busWrite(pa(0, 52), 32'h20);
    check("R11 level irq unmasked", 64'(irq), 64'd1);
    busWrite(pa(0, 52), 32'h30);
    check("R11 level irq masked again", 64'(irq), 64'd0);

    // R8 R9 overrun on pair 1
    setRes(1, 3'd5);
    for (int k = 0; k < DEPTH + 1; k++) pushFrame(1);
    busRead(pa(1, 48), rd); check("R8 overrun flag", 64'(rd), 64'h20);
    busRead(pa(0, 48), rd); check("R8 other pair no overrun", 64'(rd[5]), 64'd0);
    busWrite(pa(1, 52), 32'h10);
    check("R11 overrun irq", 64'(irq), 64'd1);
    busRead(pa(1, 56), rd);
    busRead(pa(1, 48), rd); check("R9 clear by read", 64'(rd), 64'h0);
    check("R11 irq after clear", 64'(irq), 64'd0);
    pushFrame(1);
    busRead(pa(1, 48), rd); check("R8 overrun again", 64'(rd), 64'h20);
    busWrite(pa(1, 56), 0);
    busRead(pa(1, 48), rd); check("R9 clear by write", 64'(rd), 64'h0);
    busWrite(pa(1, 52), 32'h30);
    runPairs(4'b0010, 6);
    compareRx(1, "R8 R12 dropped frames absent");

    // R5 enable hierarchy on pair 2
    busWrite(4, 0);
    busWrite(pa(2, 60), 1);
    pushFrame(2); pushFrame(2);
    busWrite(pa(2, 40), 1);
    waitFrames(3);
    check("R5 block off no output", 64'(rxQ[2].size()), 64'd0);
    busRead(pa(2, 48), rd); check("R5 block off fifo untouched", 64'(rd), 64'h0);
    busWrite(4, 1);
    busWrite(0, 0);
    waitFrames(3);
    check("R5 global off no output", 64'(rxQ[2].size()), 64'd0);
    busRead(pa(2, 48), rd); check("R5 global off fifo untouched", 64'(rd), 64'h0);
    busWrite(0, 1);
    waitFrames(4);
    busWrite(pa(2, 40), 0);
    waitFrames(1);
    compareRx(2, "R5 all enables on");

    // R6 underrun sends zeros
    begin
      logic seen;
      seen = 1'b0;
      busWrite(pa(0, 40), 1);
      repeat (3 * FRAME_CLKS) begin @(negedge clk); if (sdOut[0]) seen = 1'b1; end
      busWrite(pa(0, 40), 0);
      check("R6 empty fifo zero line", 64'(seen), 64'd0);
    end

    // R10 flush
    for (int p = 0; p < NP; p++) busWrite(pa(p, 60), 0);
    for (int k = 0; k < 3; k++) begin pushFrame(0); pushFrame(3); end
    pushFrame(1);
    busWrite(8, 0);
    busRead(pa(0, 48), rd); check("R10 flush bit0 clear ignored", 64'(rd), 64'h0);
    busWrite(8, 1);
    for (int p = 0; p < NP; p++) begin
      busRead(pa(p, 48), rd); check("R10 flush empties", 64'(rd), 64'h10);
      expQ[p].delete(); cntModel[p] = 0;
    end
    runPairs(4'b1111, 2);
    for (int p = 0; p < NP; p++) check("R10 nothing sent after flush", 64'(rxQ[p].size()), 64'd0);

    // R3 random rounds
    for (int round = 0; round < 3; round++) begin
      for (int p = 0; p < NP; p++) begin
        int pick, n;
        pick = $urandom_range(0, 2);
        setRes(p, (pick == 0) ? 3'd2 : (pick == 1) ? 3'd4 : 3'd5);
        n = $urandom_range(1, DEPTH);
        for (int k = 0; k < n; k++) pushFrame(p);
      end
      runPairs(4'b1111, 6);
      for (int p = 0; p < NP; p++) compareRx(p, "R3 random round");
    end

    doneFlag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule